// File: doc/BRIEF.md
# Ring Buffer Pointer Manager

This block keeps the four word addresses that describe a circular buffer held in memory: the first word of the ring, the address one past its last word, the write pointer and the read pointer. Software issues one command per cycle on a command lane. Load commands set the addresses. An increment command checks, wraps and updates a pointer in a single cycle, with no stall. It returns either an address that software may use at once, or zero when no slot is available.

A second issue slot, the pop lane, lets a consumer advance the read pointer in the same cycle that the command lane is used. The pop lane is ordered before the command lane, so a producer sees a slot freed by a pop in that same cycle. Both result outputs are combinational. They are valid in the cycle the command is presented, and the pointer state changes on the next rising clock edge. The block performs no memory accesses of its own.

Top module: `ring_ptr_mgr`

## Requirements
- R1: After synchronous active-low reset all four addresses are zero, so the ring reads as empty and a pop returns zero.
- R2: Opcode 1 loads the ring start and also sets both pointers to that value. Opcode 2 loads the ring end, opcode 3 loads the write pointer and opcode 4 loads the read pointer.
- R3: Opcode 5 (write advance) returns the current write pointer and moves the write pointer forward by one 4-byte word.
- R4: When a pointer advanced by one word equals the ring end, the pointer takes the ring start value instead.
- R5: If the wrapped next write address equals the read pointer (full), opcode 5 returns zero and the write pointer keeps its value.
- R6: Opcode 6 (read advance) returns the current read pointer and advances it by one word under the wrap rule of R4.
- R7: If the read pointer equals the write pointer (empty), a read advance on either lane returns zero and the read pointer keeps its value.
- R8: A pop on the pop lane is applied before the command on the command lane in the same cycle. A full check or an empty check on the command lane therefore sees the read pointer after the pop.
- R9: The command result is zero for load opcodes, for opcode 0, for the reserved opcode 7 and whenever cmd_valid is low. Opcodes 0 and 7, and any command with cmd_valid low, leave all state unchanged. pop_addr is zero when pop_valid is low.
- R10: Loaded addresses have their two low bits cleared, so every returned address is word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is present on the command lane |
| cmd_op | input | 3 | Opcode: 0 none, 1 load start, 2 load end, 3 load write ptr, 4 load read ptr, 5 write advance, 6 read advance, 7 reserved |
| cmd_data | input | 32 | Address operand for load opcodes |
| cmd_result | output | 32 | Address granted by an advance, or zero |
| pop_valid | input | 1 | Read-advance request on the pop lane |
| pop_addr | output | 32 | Address granted to the pop lane, or zero |

## Verification
A wrong pointer shows up on the next advance command. That command returns the wrong address, or it returns zero when a slot is free (or the reverse). The fault is therefore visible one cycle after the bad state is written, at the latest when that pointer is next advanced. A wrong ring end or ring start appears only when a pointer reaches the wrap boundary. For this reason the bench walks both pointers around a small four-word ring, fills it, drains it, and combines pops with writes and reads in the same cycle.

// File: rtl/ring_ptr_pkg.sv
// Shared opcode encoding and decoded control bundle for the ring pointer manager.
package ring_ptr_pkg;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_LD_START = 3'd1,
        OP_LD_END   = 3'd2,
        OP_LD_WP    = 3'd3,
        OP_LD_RP    = 3'd4,
        OP_ADV_WP   = 3'd5,
        OP_ADV_RP   = 3'd6,
        OP_RSVD     = 3'd7
    } ring_op_e;

    typedef struct packed {
        logic ld_start;
        logic ld_end;
        logic ld_wp;
        logic ld_rp;
        logic adv_wp;
        logic adv_rp;
    } ring_ctl_t;

endpackage

// File: rtl/ring_ptr_decode.sv
// Turns a command-lane opcode into one-hot control strobes.
// Assumes: strobes are all low when cmd_valid is low; the reserved opcode decodes to nothing.
module ring_ptr_decode
    import ring_ptr_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    output ring_ctl_t  ctl
);

    // Decode opcode into control strobes.
    always_comb begin
        ctl = '0;
        if (cmd_valid) begin
            unique case (ring_op_e'(cmd_op))
                OP_LD_START: ctl.ld_start = 1'b1;
                OP_LD_END:   ctl.ld_end   = 1'b1;
                OP_LD_WP:    ctl.ld_wp    = 1'b1;
                OP_LD_RP:    ctl.ld_rp    = 1'b1;
                OP_ADV_WP:   ctl.adv_wp   = 1'b1;
                OP_ADV_RP:   ctl.adv_rp   = 1'b1;
                default:     ctl = '0;
            endcase
        end
    end

endmodule

// File: rtl/ring_ptr_step.sv
// Computes the pointer one word ahead, wrapping to ring start when it reaches ring end.
// Assumes: ring end is exclusive and word-aligned like the pointer.
module ring_ptr_step #(
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] ring_start,
    input  logic [AW-1:0] ring_end,
    output logic [AW-1:0] ptr_next
);

    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [AW-1:0] bumped;

    // Advance by one word and apply the wrap rule.
    always_comb begin
        bumped   = ptr + STEP;
        ptr_next = (bumped == ring_end) ? ring_start : bumped;
    end

endmodule

// File: rtl/ring_ptr_mgr.sv
// Ring buffer pointer manager: holds ring start/end and write/read pointers,
// performs atomic advance-with-wrap plus full/empty check in one cycle.
// Assumes: pop lane is ordered before the command lane; results are combinational.
module ring_ptr_mgr
    import ring_ptr_pkg::*;
#(
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_data,
    output logic [AW-1:0] cmd_result,
    input  logic          pop_valid,
    output logic [AW-1:0] pop_addr
);

    localparam int            ALIGN_BITS = $clog2(WORD_BYTES);
    localparam logic [AW-1:0] ALIGN_MASK = AW'(WORD_BYTES - 1);

    ring_ctl_t     ctl;
    logic [AW-1:0] start_q, end_q, wp_q, rp_q;
    logic [AW-1:0] din;
    logic [AW-1:0] rp_step, rp_mid, rp_mid_step, wp_step;
    logic          pop_go, full, empty_cmd;

    ring_ptr_decode u_decode (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .ctl       (ctl)
    );

    ring_ptr_step #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_step_pop (
        .ptr (rp_q), .ring_start (start_q), .ring_end (end_q), .ptr_next (rp_step)
    );

    ring_ptr_step #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_step_rd (
        .ptr (rp_mid), .ring_start (start_q), .ring_end (end_q), .ptr_next (rp_mid_step)
    );

    ring_ptr_step #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_step_wr (
        .ptr (wp_q), .ring_start (start_q), .ring_end (end_q), .ptr_next (wp_step)
    );

    // Word-align the load operand.
    always_comb din = cmd_data & ~ALIGN_MASK;

    // Pop lane first: read pointer as seen by the command lane.
    always_comb begin
        pop_go   = pop_valid && (rp_q != wp_q);
        rp_mid   = pop_go ? rp_step : rp_q;
        pop_addr = pop_go ? rp_q : '0;
    end

    // Command lane full/empty checks and result selection.
    always_comb begin
        full      = (wp_step == rp_mid);
        empty_cmd = (rp_mid == wp_q);
        if (ctl.adv_wp)      cmd_result = full ? '0 : wp_q;
        else if (ctl.adv_rp) cmd_result = empty_cmd ? '0 : rp_mid;
        else                 cmd_result = '0;
    end

    // Register update for all four addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
            wp_q    <= '0;
            rp_q    <= '0;
        end else begin
            if (ctl.ld_start) start_q <= din;
            if (ctl.ld_end)   end_q   <= din;
            if (ctl.ld_start || ctl.ld_wp)  wp_q <= din;
            else if (ctl.adv_wp && !full)   wp_q <= wp_step;
            if (ctl.ld_start || ctl.ld_rp)  rp_q <= din;
            else if (ctl.adv_rp && !empty_cmd) rp_q <= rp_mid_step;
            else                            rp_q <= rp_mid;
        end
    end

    AST_FULL_HOLDS_WP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.adv_wp && wp_step == rp_mid) |=> $stable(wp_q)); // R5

    AST_EMPTY_HOLDS_RP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && rp_q == wp_q && !ctl.ld_start && !ctl.ld_rp) |=> $stable(rp_q)); // R7

    AST_IDLE_RESULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.adv_wp && !ctl.adv_rp) |-> (cmd_result == '0)); // R9

    AST_RESULT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_result[ALIGN_BITS-1:0] == '0) && (pop_addr[ALIGN_BITS-1:0] == '0)); // R10

    AST_NO_POP_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_valid |-> (pop_addr == '0)); // R9

endmodule

// File: tb/ring_ptr_mgr_tb.sv
module ring_ptr_mgr_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [31:0] cmd_data;
    logic [31:0] cmd_result;
    logic        pop_valid;
    logic [31:0] pop_addr;

    int checks = 0;
    int errors = 0;

    ring_ptr_mgr u_dut (
        .clk (clk), .rst_n (rst_n),
        .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_data (cmd_data),
        .cmd_result (cmd_result),
        .pop_valid (pop_valid), .pop_addr (pop_addr)
    );

    always #10 clk = ~clk;

    // Drive one cycle, compare both lane results before the commit edge.
    task automatic step(input logic v, input logic [2:0] op, input logic [31:0] d,
                        input logic pv, input logic [31:0] exp_r,
                        input logic [31:0] exp_p, input string req);
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_data = d; pop_valid = pv;
        #3;
        checks++;
        if (cmd_result !== exp_r || pop_addr !== exp_p) begin
            errors++;
            $display("FAIL %s: result=%h pop=%h expected result=%h pop=%h",
                     req, cmd_result, pop_addr, exp_r, exp_p);
        end
        @(posedge clk);
        #1;
        cmd_valid = 1'b0; pop_valid = 1'b0; cmd_op = 3'd0; cmd_data = '0;
    endtask

    task automatic t_reset();
        step(1'b0, 3'd0, 32'h0, 1'b1, 32'h0, 32'h0, "R1 pop empty after reset");
        step(1'b1, 3'd6, 32'h0, 1'b0, 32'h0, 32'h0, "R1 read advance empty after reset");
    endtask

    task automatic t_fill();
        step(1'b1, 3'd1, 32'h0000_1003, 1'b0, 32'h0, 32'h0, "R10 load start unaligned");
        step(1'b1, 3'd2, 32'h0000_1010, 1'b0, 32'h0, 32'h0, "R9 load end result zero");
        step(1'b1, 3'd5, 32'h0, 1'b0, 32'h1000, 32'h0, "R2 R3 first write at start");
        step(1'b1, 3'd5, 32'h0, 1'b0, 32'h1004, 32'h0, "R3 second write");
        step(1'b1, 3'd5, 32'h0, 1'b0, 32'h1008, 32'h0, "R3 third write");
        step(1'b1, 3'd5, 32'h0, 1'b0, 32'h0, 32'h0, "R5 full returns zero");
        step(1'b1, 3'd5, 32'h0, 1'b0, 32'h0, 32'h0, "R5 still full");
    endtask

    task automatic t_wrap();
        step(1'b1, 3'd6, 32'h0, 1'b0, 32'h1000, 32'h0, "R6 read advance");
        step(1'b1, 3'd5, 32'h0, 1'b0, 32'h100C, 32'h0, "R4 write wraps");
        step(1'b1, 3'd5, 32'h0, 1'b0, 32'h0, 32'h0, "R5 full after wrap");
    endtask

    task automatic t_same_cycle();
        step(1'b1, 3'd5, 32'h0, 1'b1, 32'h1000, 32'h1004, "R8 pop frees slot for write");
    endtask

    task automatic t_drain();
        step(1'b1, 3'd6, 32'h0, 1'b0, 32'h1008, 32'h0, "R6 drain 1");
        step(1'b1, 3'd6, 32'h0, 1'b0, 32'h100C, 32'h0, "R6 drain 2 wraps read");
        step(1'b1, 3'd6, 32'h0, 1'b0, 32'h1000, 32'h0, "R4 read after wrap");
        step(1'b1, 3'd6, 32'h0, 1'b0, 32'h0, 32'h0, "R7 empty read advance");
        step(1'b0, 3'd0, 32'h0, 1'b1, 32'h0, 32'h0, "R7 empty pop");
    endtask

    task automatic t_ignored();
        step(1'b1, 3'd7, 32'hFFFF_FFFF, 1'b0, 32'h0, 32'h0, "R9 reserved opcode");
        step(1'b0, 3'd5, 32'h0, 1'b0, 32'h0, 32'h0, "R9 invalid advance");
        step(1'b1, 3'd0, 32'h0, 1'b0, 32'h0, 32'h0, "R9 opcode none");
        step(1'b1, 3'd5, 32'h0, 1'b0, 32'h1004, 32'h0, "R9 state untouched");
    endtask

    task automatic t_loads();
        step(1'b1, 3'd3, 32'h0000_100A, 1'b0, 32'h0, 32'h0, "R2 load write ptr");
        step(1'b1, 3'd4, 32'h0000_1008, 1'b0, 32'h0, 32'h0, "R2 load read ptr");
        step(1'b1, 3'd6, 32'h0, 1'b0, 32'h0, 32'h0, "R2 R10 loaded pointers equal");
        step(1'b1, 3'd5, 32'h0, 1'b0, 32'h1008, 32'h0, "R2 write from loaded ptr");
        step(1'b1, 3'd6, 32'h0, 1'b1, 32'h0, 32'h1008, "R8 pop before read advance");
    endtask

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = '0; pop_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fill();
        t_wrap();
        t_same_cycle();
        t_drain();
        t_ignored();
        t_loads();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule